// File: doc/BRIEF.md
# Register Access Channel Sequencer

This block sits between a host register interface and a downstream register-transaction port. The host starts a 16-bit register read or write on the downstream side with one 32-bit command write. It then follows the transaction through one status word. That word carries the captured read data, the sequencer state, a pending-request flag, an idle indication and an init-done flag.

Read and write transactions end differently. A read parks the sequencer with its data held until the host pulses the valid-clear strobe. A write returns to idle as soon as the downstream response arrives. While the sequencer is not idle, new commands are dropped. A host that never clears a finished read therefore blocks all later traffic.

The downstream request is a valid/ready stream. The block raises `req_valid` and holds every request field steady until `req_ready` is seen high at a clock edge; the downstream side applies back-pressure by keeping `req_ready` low. The response side has no ready. The block takes `rsp_valid` only while it is waiting for data, and ignores a response at any other time.

Top module: `wrac_channel`

## Requirements
- R1: A command word is decoded as follows. Bit 31 is the write flag (1 = write, 0 = read). Bits [30:16] are the halfword address. Bits [15:0] are the write data. These appear on `req_write`, `req_addr` and `req_wdata` while the request is presented.
- R2: `status_word` has these fields. Bits [15:0] hold the last captured read data. Bits [18:16] hold the state code. Bit 19 is the request flag. Bit 20 is the idle flag. Bit 21 follows the `init_done` input. Bits [31:22] read 0.
- R3: State codes are idle = 0, requesting = 2, waiting for data = 4 and waiting for valid-clear = 6. An accepted command moves the state from 0 to 2 at the next edge.
- R4: In state 2, `req_valid` and the request flag are 1. The request fields stay stable until an edge with `req_ready` high, and that edge moves the state to 4.
- R5: In state 4, a response with `rsp_valid` high on a read captures `rsp_rdata` into bits [15:0] and moves the state to 6. The state and data then hold there.
- R6: A `vld_clr` pulse in state 6 returns the state to 0. In any other state, `vld_clr` has no effect.
- R7: On a write, the response in state 4 returns the state directly to 0 and leaves the read data unchanged.
- R8: A command written while the state is not 0 is ignored. The state, the request fields and the request flag are left unchanged.
- R9: While `chan_en` is 0, commands are ignored and the state stays at 0.
- R10: The idle flag (bit 20) is 1 in states 0 and 6, and 0 while a downstream transaction is outstanding (states 2 and 4).
- R11: After reset the state is 0, the read data is 0, the request flag is 0 and the idle flag is 1.
- R12: A `rsp_valid` outside state 4 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; commands are accepted only when 1 |
| init_done | input | 1 | Init-done flag reported in status bit 21 |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 32 | Command register write value |
| vld_clr | input | 1 | Valid-clear strobe |
| status_word | output | 32 | Packed status and read data |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request ready |
| req_write | output | 1 | Request is a write |
| req_addr | output | 15 | Request halfword address |
| req_wdata | output | 16 | Request write data |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_rdata | input | 16 | Downstream response read data |

## Verification
Several behaviours are checked by assertions on every cycle. These are: request fields held steady under back-pressure, the parked read state holding its data until cleared, writes returning straight to idle, read data matching the captured response, the idle flag dropping whenever a request is presented, and the request flag rising only after an enabled command in state 0. Other behaviours only the directed scenarios can show. These are the exact field decode of a command word, the reset status value, commands dropped while busy or disabled, and stray valid-clear or response pulses having no effect. Each of these is judged at the status word and request pins after the stimulus.

// File: rtl/wrac_pkg.sv
package wrac_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 1 + ADDR_W + DATA_W;
  localparam int STS_W  = 32;
  localparam int ST_W   = 3;

  // status field positions (decoded by the host)
  localparam int STS_ST_LO   = DATA_W;
  localparam int STS_REQ_BIT = DATA_W + ST_W;
  localparam int STS_IDL_BIT = STS_REQ_BIT + 1;
  localparam int STS_INI_BIT = STS_IDL_BIT + 1;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_DATA = 3'd4,
    ST_WAIT_CLR  = 3'd6
  } chan_state_e;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/wrac_cmd_decode.sv
module wrac_cmd_decode
  import wrac_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_t             cmd_o
);
  always_comb begin
    cmd_o.is_write = word_i[CMD_W-1];
    cmd_o.addr     = word_i[DATA_W +: ADDR_W];
    cmd_o.data     = word_i[DATA_W-1:0];
  end
endmodule

// File: rtl/wrac_fsm.sv
module wrac_fsm
  import wrac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cmd_wr,
  input  cmd_t              cmd_in,
  input  logic              vld_clr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output chan_state_e       state_o,
  output cmd_t              cmd_q_o,
  output logic [DATA_W-1:0] rdata_q_o
);
  chan_state_e       state_q;
  cmd_t              cmd_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr && chan_en) begin
            cmd_q   <= cmd_in;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready) state_q <= ST_WAIT_DATA;
        end
        ST_WAIT_DATA: begin
          if (rsp_valid) begin
            if (cmd_q.is_write) begin
              state_q <= ST_IDLE;
            end else begin
              rdata_q <= rsp_rdata;
              state_q <= ST_WAIT_CLR;
            end
          end
        end
        ST_WAIT_CLR: begin
          if (vld_clr) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cmd_q_o   = cmd_q;
  assign rdata_q_o = rdata_q;
endmodule

// File: rtl/wrac_status_pack.sv
module wrac_status_pack
  import wrac_pkg::*;
(
  input  chan_state_e       state_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              init_done_i,
  output logic              req_flag_o,
  output logic [STS_W-1:0]  status_o
);
  logic idle_flag;

  always_comb begin
    req_flag_o = (state_i == ST_REQ);
    idle_flag  = (state_i == ST_IDLE) || (state_i == ST_WAIT_CLR);
    status_o   = '0;
    status_o[DATA_W-1:0]         = rdata_i;
    status_o[STS_ST_LO +: ST_W]  = state_i;
    status_o[STS_REQ_BIT]        = req_flag_o;
    status_o[STS_IDL_BIT]        = idle_flag;
    status_o[STS_INI_BIT]        = init_done_i;
  end
endmodule

// File: rtl/wrac_channel.sv
module wrac_channel
  import wrac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              init_done,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              vld_clr,
  output logic [STS_W-1:0]  status_word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  cmd_t              cmd_dec;
  cmd_t              cmd_q;
  chan_state_e       state;
  logic [DATA_W-1:0] rdata_q;
  logic              req_flag;

  wrac_cmd_decode u_dec (
    .word_i (cmd_word),
    .cmd_o  (cmd_dec)
  );

  wrac_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .cmd_wr    (cmd_wr),
    .cmd_in    (cmd_dec),
    .vld_clr   (vld_clr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .state_o   (state),
    .cmd_q_o   (cmd_q),
    .rdata_q_o (rdata_q)
  );

  wrac_status_pack u_sts (
    .state_i     (state),
    .rdata_i     (rdata_q),
    .init_done_i (init_done),
    .req_flag_o  (req_flag),
    .status_o    (status_word)
  );

  assign req_valid = req_flag;
  assign req_write = cmd_q.is_write;
  assign req_addr  = cmd_q.addr;
  assign req_wdata = cmd_q.data;
endmodule

// File: rtl/wrac_channel_checker.sv
module wrac_channel_checker
  import wrac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              cmd_wr,
  input logic              vld_clr,
  input logic [STS_W-1:0]  status_word,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  logic [ST_W-1:0] st;
  assign st = status_word[STS_ST_LO +: ST_W];

  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd2 || st == 3'd4 || st == 3'd6));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));

  p_read_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && rsp_valid && !req_write) |=>
      (st == 3'd6 && status_word[DATA_W-1:0] == $past(rsp_rdata)));

  p_park_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && !vld_clr) |=> (st == 3'd6 && $stable(status_word[DATA_W-1:0])));

  p_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && rsp_valid && req_write) |=> (st == 3'd0));

  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[STS_REQ_BIT]) |-> $past(st == 3'd0 && cmd_wr && chan_en));

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !chan_en) |=> (st == 3'd0));

  p_busy_not_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !status_word[STS_IDL_BIT]);
endmodule

bind wrac_channel wrac_channel_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .cmd_wr      (cmd_wr),
  .vld_clr     (vld_clr),
  .status_word (status_word),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/wrac_channel_test.sv
module wrac_channel_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        init_done = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        vld_clr = 1'b0;
  logic [31:0] status_word;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [14:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrac_channel uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .init_done(init_done),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .vld_clr(vld_clr),
    .status_word(status_word), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one clock: inputs were set after a negedge; step past posedge to next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sts(input logic [15:0] d, input logic [2:0] s,
                                      input logic rq, input logic idl, input logic ini);
    return {10'b0, ini, idl, rq, s, d};
  endfunction

  task automatic issue(input logic wr, input logic [14:0] a, input logic [15:0] d);
    cmd_word = {wr, a, d};
    cmd_wr   = 1'b1;
    step();
    cmd_wr   = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset status", status_word, sts(16'h0, 3'd0, 1'b0, 1'b1, 1'b0));
    check("R11 reset req_valid", {31'b0, req_valid}, 32'd0);
    init_done = 1'b1;
    #1;
    check("R2 init flag bit21", status_word, sts(16'h0, 3'd0, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_read(input logic [14:0] a, input logic [15:0] d, input int stall);
    issue(1'b0, a, d ^ 16'hffff);
    check("R3 R4 req state", status_word, sts(16'h0 | status_word[15:0], 3'd2, 1'b1, 1'b0, 1'b1));
    check("R1 read decode", {req_valid, req_write, req_addr}, {1'b1, 1'b0, a});
    for (int i = 0; i < stall; i++) begin
      step();
      check("R4 held under backpressure", {req_valid, status_word[18:16], req_addr}, {1'b1, 3'd2, a});
    end
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    check("R4 to wait-data", {req_valid, status_word[20:16]}, {1'b0, 5'b0_0100});
    rsp_rdata = d;
    rsp_valid = 1'b1;
    step();
    rsp_valid = 1'b0;
    rsp_rdata = 16'h0;
    check("R5 R10 parked read", status_word, sts(d, 3'd6, 1'b0, 1'b1, 1'b1));
    step();
    step();
    check("R5 park holds", status_word, sts(d, 3'd6, 1'b0, 1'b1, 1'b1));
    vld_clr = 1'b1;
    step();
    vld_clr = 1'b0;
    check("R6 clear to idle", status_word, sts(d, 3'd0, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_write(input logic [14:0] a, input logic [15:0] d);
    logic [15:0] old = status_word[15:0];
    issue(1'b1, a, d);
    check("R1 write decode", {req_valid, req_write, req_addr, req_wdata}, {1'b1, 1'b1, a, d});
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    rsp_rdata = 16'hdead;
    rsp_valid = 1'b1;
    step();
    rsp_valid = 1'b0;
    check("R7 write back to idle", status_word, sts(old, 3'd0, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_busy_and_stray();
    // R12: response while requesting is ignored
    issue(1'b0, 15'h1234, 16'h0);
    rsp_rdata = 16'hbeef;
    rsp_valid = 1'b1;
    step();
    rsp_valid = 1'b0;
    check("R12 rsp in req ignored", status_word[19:16], 4'b1010);
    // R8: command while requesting
    issue(1'b1, 15'h7777, 16'h5555);
    check("R8 busy cmd in req", {req_write, req_addr, status_word[19:16]}, {1'b0, 15'h1234, 4'b1010});
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    rsp_rdata = 16'h5aa5;
    rsp_valid = 1'b1;
    step();
    rsp_valid = 1'b0;
    check("R5 data after stray", status_word[15:0], 16'h5aa5);
    issue(1'b1, 15'h0042, 16'h1111);
    check("R8 busy cmd in park", {req_valid, req_addr, status_word[19:16]}, {1'b0, 15'h1234, 4'b0110});
    vld_clr = 1'b1;
    step();
    vld_clr = 1'b0;
    check("R6 idle after park", status_word[19:16], 4'b0000);
    // R6: clear in idle ignored; R12: response in idle ignored
    vld_clr = 1'b1;
    rsp_valid = 1'b1;
    rsp_rdata = 16'h0bad;
    step();
    vld_clr = 1'b0;
    rsp_valid = 1'b0;
    check("R6 R12 stray in idle", status_word, sts(16'h5aa5, 3'd0, 1'b0, 1'b1, 1'b1));
  endtask

  task automatic t_disabled();
    chan_en = 1'b0;
    issue(1'b1, 15'h0101, 16'h2222);
    check("R9 disabled ignores cmd", {req_valid, status_word[19:16]}, {1'b0, 4'b0000});
    chan_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n   = 1'b1;
    chan_en = 1'b1;
    step();
    t_read(15'h5e05, 16'h5aa5, 0);
    t_read(15'h0001, 16'h8001, 3);
    t_write(15'h5e06, 16'ha55a);
    t_busy_and_stray();
    t_disabled();
    t_write(15'h7fff, 16'hffff);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule